// File: doc/BRIEF.md
# Excitation Peak Sample-Time Detector

A resolver's sine and cosine outputs are the excitation carrier scaled by the shaft angle. They give the most information when they are sampled at the crest of the carrier. Delay in the analog path moves that crest by an unknown amount, so this block finds it by measurement. Samples arrive many times per excitation period on a sample-valid strobe. An internal phase counter numbers each sample within the period and wraps at a programmable last index. The block watches one channel, either sine or cosine, chosen by a select pin.

Detection starts when `enable` goes high. The block does nothing until one selected sample has a magnitude strictly above a programmable threshold. This keeps unsettled, weak input out of the search. From the next period boundary on, the block records in each period the phase index of the largest signed sample. It accepts that index once several consecutive periods agree with their predecessor to within a small tolerance. It then raises `done`, holds the phase index as the ideal sample time, and reports whether the trough of that period was deeper than its crest. A deeper trough means the recovered angle may need a half-turn correction. Dropping `enable` clears the search.

Top module: `excite_peak_finder`

## Requirements
- R1: After reset, `done`, `flip180`, `ideal_time` and `phase_now` are all zero.
- R2: `phase_now` advances by one for each cycle with `smp_valid` high. When `smp_valid` is high on a cycle where `phase_now` is at or above `period_last`, the next value is 0, so a period holds `period_last`+1 samples.
- R3: No period is evaluated until a selected sample with `smp_valid` high has an absolute value strictly greater than the unsigned `thresh`. The first evaluated period is the one that starts after the period in which that happened. If the threshold is never crossed, `done` stays 0 and `ideal_time` stays 0.
- R4: In each evaluated period, the candidate index is the phase of the largest signed sample on the selected channel (`chan_sel` 0 = sine, 1 = cosine). When two samples tie, the earliest phase wins. Samples on the other channel are ignored.
- R5: `done` rises at the end of the evaluated period whose candidate completes a run of 4 consecutive candidates, each differing by at most 1 from the one before it. `ideal_time` then holds that final candidate.
- R6: A candidate that differs from the previous one by more than 1 starts a new run of length 1.
- R7: When `done` rises, `flip180` is 1 exactly when, in that final period, the most negative selected sample's magnitude exceeds the largest sample.
- R8: While `enable` stays high after `done`, the values of `done`, `ideal_time` and `flip180` hold regardless of input. One cycle with `enable` low clears `done`, `flip180`, `ideal_time`, the threshold arming and the run. The phase counter keeps running.
- R9: Cycles with `smp_valid` low change nothing, whatever the sample inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs detection while high; low clears it |
| chan_sel | input | 1 | 0 selects sine, 1 selects cosine |
| smp_valid | input | 1 | Marks a new oversampled sample pair |
| sin_smp | input | SAMPLE_W | Signed sine-channel sample |
| cos_smp | input | SAMPLE_W | Signed cosine-channel sample |
| thresh | input | SAMPLE_W | Unsigned arming magnitude |
| period_last | input | PHASE_W | Last phase index of a period |
| phase_now | output | PHASE_W | Phase index of the next sample |
| ideal_time | output | PHASE_W | Detected peak phase |
| done | output | 1 | Detected result is valid |
| flip180 | output | 1 | Trough dominated the final period |

## Verification
The bench keeps the default parameters: 16-bit samples, an 8-bit phase, a run length of 4 and a tolerance of 1. It drives the period length through `period_last`, so one build covers periods of 8, 16, 32 and the full 256 counts, including peaks near index 200. With a 16-bit threshold and large negative samples, the bench reaches both the case where the threshold is never crossed and the case where the trough wins. The tolerance of 1 lets drifting chains (9-10-11-10) pass while jumps of 4 force a restart.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

  typedef enum logic {CH_SIN = 1'b0, CH_COS = 1'b1} chan_e;

  // absolute value of a sign-extended sample
  function automatic logic [31:0] mag32(input logic signed [31:0] v);
    return (v < 0) ? 32'(-v) : 32'(v);
  endfunction

  // two phase indices agree when their distance is within tol
  function automatic logic near(input int unsigned a, input int unsigned b,
                                input int unsigned tol);
    return ((a > b) ? (a - b) : (b - a)) <= tol;
  endfunction

  // trough dominates when its magnitude exceeds the crest value
  function automatic logic trough_wins(input logic signed [31:0] crest,
                                       input logic signed [31:0] trough);
    return (trough < 0) && (-trough > crest);
  endfunction

endpackage

// File: rtl/ppf_phase_ctr.sv
module ppf_phase_ctr #(
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic [PHASE_W-1:0] last_idx,
  output logic [PHASE_W-1:0] phase,
  output logic               wrap
);

  assign wrap = adv && (phase >= last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase <= '0;
    else if (adv) phase <= wrap ? '0 : phase + 1'b1;
  end

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> phase == '0);
  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wrap |=> phase == $past(phase) + 1'b1);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(phase));

endmodule

// File: rtl/ppf_period_peak.sv
module ppf_period_peak
  import ppf_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int PHASE_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  input  logic                       first,
  input  logic [PHASE_W-1:0]         phase,
  input  logic signed [SAMPLE_W-1:0] x,
  output logic [PHASE_W-1:0]         idx_n,
  output logic                       neg_dom_n
);

  logic signed [SAMPLE_W-1:0] max_r, min_r, max_n, min_n;
  logic [PHASE_W-1:0]         idx_r;
  logic                       take_new;

  // strict compare keeps the earliest phase on ties
  always_comb begin
    take_new  = first || (x > max_r);
    max_n     = take_new ? x : max_r;
    idx_n     = take_new ? phase : idx_r;
    min_n     = (first || (x < min_r)) ? x : min_r;
    neg_dom_n = trough_wins(32'(max_n), 32'(min_n));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_r <= '0;
      min_r <= '0;
      idx_r <= '0;
    end else if (adv) begin
      max_r <= max_n;
      min_r <= min_n;
      idx_r <= idx_n;
    end
  end

  // R4
  idx_le_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> idx_n <= phase);
  // R4
  crest_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !first |=> max_r >= $past(max_r));

endmodule

// File: rtl/ppf_run_judge.sv
module ppf_run_judge
  import ppf_pkg::*;
#(
  parameter int PHASE_W    = 8,
  parameter int MATCH_RUNS = 4,
  parameter int MATCH_TOL  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               eval,
  input  logic [PHASE_W-1:0] cand_idx,
  input  logic               cand_neg,
  output logic               done,
  output logic [PHASE_W-1:0] res_idx,
  output logic               res_flip
);

  localparam int CNT_W = $clog2(MATCH_RUNS + 1);

  logic [CNT_W-1:0]   run_cnt, run_nxt;
  logic [PHASE_W-1:0] prev_idx;
  logic               agrees;

  always_comb begin
    agrees  = near(32'(cand_idx), 32'(prev_idx), MATCH_TOL);
    run_nxt = (run_cnt == '0 || !agrees) ? CNT_W'(1) : run_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      prev_idx <= '0;
      done     <= 1'b0;
      res_idx  <= '0;
      res_flip <= 1'b0;
    end else if (clr) begin
      run_cnt  <= '0;
      prev_idx <= '0;
      done     <= 1'b0;
      res_idx  <= '0;
      res_flip <= 1'b0;
    end else if (eval && !done) begin
      run_cnt  <= run_nxt;
      prev_idx <= cand_idx;
      if (run_nxt == CNT_W'(MATCH_RUNS)) begin
        done     <= 1'b1;
        res_idx  <= cand_idx;
        res_flip <= cand_neg;
      end
    end
  end

  // R5
  done_only_on_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !eval |=> !done);
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr |=> done && $stable(res_idx) && $stable(res_flip));
  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval && !done && !clr && run_cnt != '0 && !agrees |=> run_cnt == CNT_W'(1));

endmodule

// File: rtl/excite_peak_finder.sv
module excite_peak_finder
  import ppf_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int PHASE_W    = 8,
  parameter int MATCH_RUNS = 4,
  parameter int MATCH_TOL  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                chan_sel,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] sin_smp,
  input  logic [SAMPLE_W-1:0] cos_smp,
  input  logic [SAMPLE_W-1:0] thresh,
  input  logic [PHASE_W-1:0]  period_last,
  output logic [PHASE_W-1:0]  phase_now,
  output logic [PHASE_W-1:0]  ideal_time,
  output logic                done,
  output logic                flip180
);

  logic signed [SAMPLE_W-1:0] sel_smp;
  logic                       over_thr, arm_evt, armed, live;
  logic                       wrap, track_adv, period_end;
  logic [PHASE_W-1:0]         cand_idx;
  logic                       cand_neg;

  assign sel_smp    = (chan_e'(chan_sel) == CH_COS) ? $signed(cos_smp) : $signed(sin_smp);
  assign over_thr   = mag32(32'(sel_smp)) > 32'(thresh);
  assign arm_evt    = enable && smp_valid && over_thr;
  assign track_adv  = enable && live && smp_valid;
  assign period_end = track_adv && wrap;

  ppf_phase_ctr #(.PHASE_W(PHASE_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .adv(smp_valid), .last_idx(period_last),
    .phase(phase_now), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      live  <= 1'b0;
    end else if (!enable) begin
      armed <= 1'b0;
      live  <= 1'b0;
    end else begin
      if (arm_evt) armed <= 1'b1;
      if (wrap && (armed || arm_evt)) live <= 1'b1;
    end
  end

  ppf_period_peak #(.SAMPLE_W(SAMPLE_W), .PHASE_W(PHASE_W)) u_peak (
    .clk(clk), .rst_n(rst_n), .adv(track_adv), .first(phase_now == '0),
    .phase(phase_now), .x(sel_smp), .idx_n(cand_idx), .neg_dom_n(cand_neg)
  );

  ppf_run_judge #(.PHASE_W(PHASE_W), .MATCH_RUNS(MATCH_RUNS), .MATCH_TOL(MATCH_TOL)) u_judge (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .eval(period_end),
    .cand_idx(cand_idx), .cand_neg(cand_neg),
    .done(done), .res_idx(ideal_time), .res_flip(flip180)
  );

  // R3
  live_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> armed);
  // R8
  enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !done && !flip180 && ideal_time == '0);
  // R7
  flip_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip180 |-> done);

endmodule

// File: tb/excite_peak_finder_bench.sv
`timescale 1ns/1ps
module excite_peak_finder_bench;

  localparam int CLK_NS = 4;

  typedef struct packed {
    logic            chan;
    logic [7:0]      plast;
    logic [15:0]     thr;
    logic [15:0]     pamp;
    logic [15:0]     nmag;
    logic [7:0]      npos;
    logic [3:0]      quiet;
    logic [5:0][7:0] pk;
  } row_t;

  localparam int NROWS = 6;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 8'd15,  16'd1000, 16'd5000, 16'd2000, 8'd12, 4'd2, {8'd5, 8'd5, 8'd5, 8'd5, 8'd5, 8'd5}},
    '{1'b1, 8'd31,  16'd500,  16'd3000, 16'd6000, 8'd25, 4'd0, {8'd9, 8'd10, 8'd11, 8'd10, 8'd9, 8'd9}},
    '{1'b0, 8'd15,  16'd1000, 16'd4000, 16'd100,  8'd12, 4'd1, {8'd3, 8'd3, 8'd8, 8'd8, 8'd8, 8'd8}},
    '{1'b1, 8'd15,  16'd1000, 16'd4000, 16'd100,  8'd13, 4'd0, {8'd2, 8'd2, 8'd6, 8'd6, 8'd10, 8'd10}},
    '{1'b0, 8'd7,   16'd4000, 16'd3000, 16'd100,  8'd1,  4'd0, {8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd4}},
    '{1'b0, 8'd255, 16'd800,  16'd7000, 16'd300,  8'd60, 4'd1, {8'd200, 8'd201, 8'd200, 8'd201, 8'd200, 8'd201}}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        chan_sel = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] sin_smp = '0;
  logic [15:0] cos_smp = '0;
  logic [15:0] thresh = '0;
  logic [7:0]  period_last = 8'd15;
  logic [7:0]  phase_now, ideal_time;
  logic        done, flip180;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  excite_peak_finder u_excite_peak_finder (
    .clk(clk), .rst_n(rst_n), .enable(enable), .chan_sel(chan_sel),
    .smp_valid(smp_valid), .sin_smp(sin_smp), .cos_smp(cos_smp),
    .thresh(thresh), .period_last(period_last), .phase_now(phase_now),
    .ideal_time(ideal_time), .done(done), .flip180(flip180)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pk_of(input row_t r, input int i);
    return int'(r.pk[5-i]);
  endfunction

  // expected outcome: accepted at the first evaluated period i (from 1)
  // whose three preceding steps each move by at most one
  function automatic void expect_row(input row_t r, output int e_done,
                                     output int e_time, output int e_flip);
    int top;
    e_done = 0; e_time = 0; e_flip = 0;
    top = (r.pamp > r.nmag) ? int'(r.pamp) : int'(r.nmag);
    if (top <= int'(r.thr)) return;
    for (int i = 4; i <= 5; i++) begin
      bit ok = 1;
      for (int j = i - 2; j <= i; j++) begin
        int d = pk_of(r, j) - pk_of(r, j - 1);
        if (d > 1 || d < -1) ok = 0;
      end
      if (ok) begin
        e_done = 1; e_time = pk_of(r, i); e_flip = (r.nmag > r.pamp) ? 1 : 0;
        return;
      end
    end
  endfunction

  task automatic put(input bit ch, input int v);
    if (ch) begin cos_smp = 16'(v); sin_smp = '0; end
    else    begin sin_smp = 16'(v); cos_smp = '0; end
  endtask

  task automatic drive_period(input bit ch, input int last, input int ppos,
                              input int pamp, input int npos, input int nmag,
                              input int tpos, input bit gap);
    for (int ph = 0; ph <= last; ph++) begin
      int v = 0;
      if (ph == ppos || ph == tpos) v = pamp;
      if (ph == npos && nmag != 0) v = -nmag;
      smp_valid = 1'b1;
      put(ch, v);
      if (ch) sin_smp = (ph == 0) ? 16'd30000 : 16'd0;
      else    cos_smp = (ph == 0) ? 16'd30000 : 16'd0;
      @(negedge clk);
      if (gap) begin
        smp_valid = 1'b0;
        sin_smp = 16'h7fff;
        cos_smp = 16'h8000;
        @(negedge clk);
      end
    end
    smp_valid = 1'b0;
  endtask

  task automatic restart(input bit ch, input int last, input int thr);
    enable = 1'b0;
    smp_valid = 1'b0;
    @(negedge clk);
    chan_sel = ch;
    period_last = 8'(last);
    thresh = 16'(thr);
    enable = 1'b1;
    smp_valid = 1'b1;
    sin_smp = '0;
    cos_smp = '0;
    while (phase_now != 8'd0) @(negedge clk);
  endtask

  task automatic run_row(input row_t r, input bit gap);
    restart(r.chan, int'(r.plast), int'(r.thr));
    for (int q = 0; q < int'(r.quiet); q++)
      drive_period(r.chan, int'(r.plast), pk_of(r, 0), int'(r.thr) / 2, -1, 0, -1, gap);
    for (int i = 0; i < 6; i++)
      drive_period(r.chan, int'(r.plast), pk_of(r, i), int'(r.pamp),
                   int'(r.npos), int'(r.nmag), -1, gap);
  endtask

  initial begin
    #(CLK_NS * 150000);
    total++;
    bad++;
    $display("FAIL R9 watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ed, et, ef;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", int'(done), 0);
    chk("R1 flip180", int'(flip180), 0);
    chk("R1 ideal_time", int'(ideal_time), 0);
    chk("R1 phase_now", int'(phase_now), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 wrap: 8 valid samples with last index 5 -> phase 2
    period_last = 8'd5;
    smp_valid = 1'b1;
    repeat (8) @(negedge clk);
    smp_valid = 1'b0;
    chk("R2 phase after wrap", int'(phase_now), 2);
    // R9 idle cycles leave the counter alone
    sin_smp = 16'h7fff;
    repeat (5) @(negedge clk);
    chk("R9 phase idle", int'(phase_now), 2);

    // vector table: R3 R4 R5 R6 R7
    for (int k = 0; k < NROWS; k++) begin
      run_row(ROWS[k], 1'b0);
      expect_row(ROWS[k], ed, et, ef);
      chk($sformatf("R3 R5 R6 done row%0d", k), int'(done), ed);
      chk($sformatf("R4 R5 ideal_time row%0d", k), int'(ideal_time), et);
      chk($sformatf("R7 flip180 row%0d", k), int'(flip180), ef);
    end

    // R9 invalid cycles carry junk between every sample
    run_row(ROWS[0], 1'b1);
    chk("R9 gaps done", int'(done), 1);
    chk("R9 gaps ideal_time", int'(ideal_time), 5);

    // R8 result holds under new peaks
    for (int p = 0; p < 2; p++)
      drive_period(1'b0, 15, 12, 9000, 3, 20000, -1, 1'b0);
    chk("R8 hold done", int'(done), 1);
    chk("R8 hold ideal_time", int'(ideal_time), 5);
    chk("R8 hold flip180", int'(flip180), 0);
    enable = 1'b0;
    @(negedge clk);
    chk("R8 clear done", int'(done), 0);
    chk("R8 clear ideal_time", int'(ideal_time), 0);

    // R4 tie: equal crests at 4 and 9 -> earliest phase
    restart(1'b0, 15, 100);
    for (int p = 0; p < 5; p++)
      drive_period(1'b0, 15, 9, 1000, -1, 0, 4, 1'b0);
    chk("R4 tie done", int'(done), 1);
    chk("R4 tie ideal_time", int'(ideal_time), 4);

    // R5 one period short of a full run gives no result
    restart(1'b1, 7, 100);
    for (int p = 0; p < 4; p++)
      drive_period(1'b1, 7, 6, 2000, 2, 3000, -1, 1'b0);
    chk("R5 short run done", int'(done), 0);
    drive_period(1'b1, 7, 6, 2000, 2, 3000, -1, 1'b0);
    chk("R5 full run done", int'(done), 1);
    chk("R7 trough flag", int'(flip180), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule